// File: doc/BRIEF.md
# Radio Channel Tuning Sequencer

This block retunes a 2.4 GHz radio front end to a requested channel. A controller presents a channel number (1 to 14), the index of the oscillator configuration table chosen at calibration time, a flag that selects the fixed autocalibration setting instead, and the per-channel transmit power integration value. It then pulses a start strobe. The sequencer captures these inputs and looks up the synthesizer, fractional divide, oscillator and transmit gain words in internal lookup logic. It emits an ordered list of 24-bit radio register writes over a valid/ready handshake and pulses done once the last write has been accepted.

Each emitted word carries a 4-bit radio register address in bits [23:20] and a 20-bit value in bits [19:0]. A serial shifter downstream turns the words into wire-level transfers. The sequencer has no knowledge of bit timing.

Top module: `chan_tune_seq`

## Requirements
- R1: A sequence emits words in this address order: 1 (synth), 2 (divide), 3 (oscillator), 0, 0, 0, 0 (mode words), then 7 (transmit gain).
- R2: With the autocal flag low, the synth value is an 8-bit per-channel entry, zero-extended: 0x47 for channels 1-2, 0x67 for 3-6, 0x57 for 7-10, 0x77 for 11-13 and 0x4F for 14. With the flag high, a 16-bit per-channel value is used instead, equal to 0x6800 plus that entry (for example 0x684F for channel 14).
- R3: The divide value comes from one per-channel table used in both modes. Channels 1-13 repeat the cycle 0x999, 0x99B, 0x998, 0x99A starting at channel 1, and channel 14 uses 0xCCC.
- R4: In standard mode the oscillator value is selected by the channel pair (channel-1)/2 within the configuration table given by the index (0 to 10). For example, table 0 pair 0 gives 0x664D, table 3 pair 3 gives 0x645D, and table 10 pair 5 gives 0x644B. In autocal mode the value is 0x6662 for every channel.
- R5: Every oscillator value is ORed with 0x40000 before it is sent to address 3.
- R6: The four mode words at address 0 are 0x25F98, 0x25F9A, 0x25F94 and 0x27FD4, in that order.
- R7: The transmit gain word is read from a 19-entry table indexed by the power integration value (for example 0x00 gives 0x0E313, 0x0D gives 0x361D7, 0x12 gives 0x3FFFF). When the index is 19 or more, the address 7 write is skipped and the sequence still completes with done.
- R8: A word is held stable on the output with valid high until ready is sampled high.
- R9: Done is high for exactly one cycle, in the cycle after the last word is accepted.
- R10: A start strobe that arrives while a sequence is in progress is ignored. The running sequence keeps its captured inputs.
- R11: A start with channel 0 or above 14, or with the autocal flag low and a configuration index of 11 or more, produces a one-cycle error pulse and no writes.
- R12: Every output word has the register address in bits [23:20] and the value in bits [19:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| chan_i | input | 4 | Requested channel number |
| cfg_idx_i | input | 4 | Oscillator configuration table index |
| autocal_i | input | 1 | Use autocalibration settings |
| pwr_int_i | input | 8 | Transmit power integration value (gain table index) |
| wr_valid_o | output | 1 | Write word valid |
| wr_ready_i | input | 1 | Downstream accepts the word |
| wr_word_o | output | 24 | Address (23:20) plus value (19:0) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after last accepted word |
| err_o | output | 1 | One-cycle pulse on a rejected start |

## Verification
The sequence is run on four distinct settings:
- channel 1 with table 0 and full-scale gain, which pins down the base lookups;
- channel 14 in autocal mode, which separates the autocal synth and fixed oscillator paths from the standard ones and reaches the odd divide entry;
- channel 12 with the last table under irregular ready, which checks pair indexing at the table edge together with word holding;
- channel 7 with table 3, which checks a mid-table odd pair.

A gain index of 19 shows the skip path still reaching done after seven words. Rejected channels and configurations, and a start issued during a stalled sequence, show that nothing leaks out and that the captured inputs are kept.

// File: rtl/chan_tune_pkg.sv
// Package: shared widths and lookup functions for the channel tuning sequencer.
// Assumes channels are numbered from 1 and table indices are already range-checked.
package chan_tune_pkg;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 20;
    localparam int unsigned WORD_W = ADDR_W + DATA_W;

    typedef enum logic [2:0] {
        STEP_SYNTH = 3'd0,
        STEP_DIV   = 3'd1,
        STEP_VCO   = 3'd2,
        STEP_MODE0 = 3'd3,
        STEP_MODE1 = 3'd4,
        STEP_MODE2 = 3'd5,
        STEP_MODE3 = 3'd6,
        STEP_GAIN  = 3'd7
    } step_e;

    localparam logic [DATA_W-1:0] VCO_FORCE_BITS = 20'h40000;
    localparam logic [15:0]       VCO_AUTOCAL    = 16'h6662;
    localparam logic [15:0]       AUTO_SYNTH_HI  = 16'h6800;

    // Standard 8-bit synth entry per channel (1..14).
    function automatic logic [7:0] std_synth(input logic [3:0] ch);
        logic [7:0] v;
        if (ch <= 4'd2)       v = 8'h47;
        else if (ch <= 4'd6)  v = 8'h67;
        else if (ch <= 4'd10) v = 8'h57;
        else if (ch <= 4'd13) v = 8'h77;
        else                  v = 8'h4F;
        return v;
    endfunction

    // Autocal 16-bit synth entry per channel.
    function automatic logic [15:0] auto_synth(input logic [3:0] ch);
        return AUTO_SYNTH_HI | {8'h00, std_synth(ch)};
    endfunction

    // Fractional divide ratio per channel, common to both modes.
    function automatic logic [11:0] divide_ratio(input logic [3:0] ch);
        logic [3:0]  m;
        logic [11:0] v;
        m = ch - 4'd1;
        if (ch == 4'd14) v = 12'hCCC;
        else begin
            case (m[1:0])
                2'd0:    v = 12'h999;
                2'd1:    v = 12'h99B;
                2'd2:    v = 12'h998;
                default: v = 12'h99A;
            endcase
        end
        return v;
    endfunction

    // Low byte cycle shared by all oscillator tables; each table is a shifted view.
    function automatic logic [7:0] vco_low_seq(input logic [4:0] k);
        logic [7:0] v;
        case (k)
            5'd0:  v = 8'h65;
            5'd1:  v = 8'h55;
            5'd2:  v = 8'h75;
            5'd3:  v = 8'h4D;
            5'd4:  v = 8'h6D;
            5'd5:  v = 8'h5D;
            5'd6:  v = 8'h7D;
            5'd7:  v = 8'h43;
            5'd8:  v = 8'h63;
            5'd9:  v = 8'h53;
            5'd10: v = 8'h73;
            5'd11: v = 8'h4B;
            5'd12: v = 8'h6B;
            default: v = 8'h5B;
        endcase
        return v;
    endfunction

    // Oscillator word for table cfg (0..10) and channel pair (0..6).
    function automatic logic [15:0] vco_std(input logic [3:0] cfg, input logic [2:0] pair);
        logic [4:0] k;
        logic [7:0] hi;
        k = {1'b0, cfg} + 5'd3 - {3'b000, pair[2:1]};
        if (!pair[0])          hi = 8'h66;
        else if (pair == 3'd1) hi = 8'h60;
        else                   hi = 8'h64;
        return {hi, vco_low_seq(k)};
    endfunction

    // Transmit gain word per power integration index (valid for 0..18).
    function automatic logic [19:0] tx_gain(input logic [4:0] idx);
        logic [19:0] v;
        case (idx)
            5'h00: v = 20'h0E313;
            5'h01: v = 20'h0FB13;
            5'h02: v = 20'h0E093;
            5'h03: v = 20'h0F893;
            5'h04: v = 20'h0EA93;
            5'h05: v = 20'h1F093;
            5'h06: v = 20'h1F493;
            5'h07: v = 20'h1F693;
            5'h08: v = 20'h1F393;
            5'h09: v = 20'h1F35B;
            5'h0A: v = 20'h1E6DB;
            5'h0B: v = 20'h1FF3F;
            5'h0C: v = 20'h1FFFF;
            5'h0D: v = 20'h361D7;
            5'h0E: v = 20'h37FBF;
            5'h0F: v = 20'h3FF8B;
            5'h10: v = 20'h3FF33;
            5'h11: v = 20'h3FB3F;
            default: v = 20'h3FFFF;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/chan_tune_ctrl.sv
// Module: chan_tune_ctrl
// Captures the request on start, validates it, steps through the write list
// under valid/ready and produces done / error pulses.
// Assumes the caller supplies gain_ok derived from the captured power value.
module chan_tune_ctrl
    import chan_tune_pkg::*;
#(
    parameter int unsigned CHAN_W   = 4,
    parameter int unsigned CFG_W    = 4,
    parameter int unsigned PWR_W    = 8,
    parameter int unsigned CHAN_MAX = 14,
    parameter int unsigned NUM_CFG  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic              auto_i,
    input  logic [PWR_W-1:0]  pwr_i,
    input  logic              ready_i,
    input  logic              gain_ok_i,
    output logic              valid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output step_e             step_o,
    output logic [CHAN_W-1:0] chan_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              auto_q,
    output logic [PWR_W-1:0]  pwr_q
);

    typedef enum logic {ST_IDLE, ST_SEND} state_e;

    state_e state_q;
    step_e  step_q;
    logic   req_ok;
    logic   accept;
    logic   last_step;

    // Request is legal when channel is in range and a standard table exists.
    always_comb begin
        req_ok = (chan_i >= CHAN_W'(1)) && (chan_i <= CHAN_W'(CHAN_MAX))
                 && (auto_i || (cfg_i < CFG_W'(NUM_CFG)));
    end

    // Transfer and end-of-list detection for the current step.
    always_comb begin
        accept    = (state_q == ST_SEND) && ready_i;
        last_step = gain_ok_i ? (step_q == STEP_GAIN) : (step_q == STEP_MODE3);
    end

    // Main sequencing state, step counter and pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= STEP_SYNTH;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (req_ok) begin
                            state_q <= ST_SEND;
                            step_q  <= STEP_SYNTH;
                        end else begin
                            err_o <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (accept) begin
                        if (last_step) begin
                            state_q <= ST_IDLE;
                            done_o  <= 1'b1;
                        end else begin
                            step_q <= step_e'(step_q + 3'd1);
                        end
                    end
                end
            endcase
        end
    end

    // Input capture, only while idle so a running list keeps its request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            cfg_q  <= '0;
            auto_q <= 1'b0;
            pwr_q  <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            chan_q <= chan_i;
            cfg_q  <= cfg_i;
            auto_q <= auto_i;
            pwr_q  <= pwr_i;
        end
    end

    // Output views of the state.
    always_comb begin
        valid_o = (state_q == ST_SEND);
        busy_o  = (state_q == ST_SEND);
        step_o  = step_q;
    end

    // Done is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // A rejected start never opens a write list.
    p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o && !done_o);

    // A start during a running list does not disturb the captured request.
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(chan_q) && $stable(auto_q) && $stable(cfg_q)));

endmodule

// File: rtl/chan_tune_rom.sv
// Module: chan_tune_rom
// Builds the 24-bit write word for the current step from the captured request
// using the lookup functions; also reports whether the gain index is in range.
// Assumes channel and table index were validated before capture.
module chan_tune_rom
    import chan_tune_pkg::*;
#(
    parameter int unsigned CHAN_W     = 4,
    parameter int unsigned CFG_W      = 4,
    parameter int unsigned PWR_W      = 8,
    parameter int unsigned GAIN_DEPTH = 19
) (
    input  step_e              step_i,
    input  logic [CHAN_W-1:0]  chan_i,
    input  logic [CFG_W-1:0]   cfg_i,
    input  logic               auto_i,
    input  logic [PWR_W-1:0]   pwr_i,
    output logic               gain_ok_o,
    output logic [WORD_W-1:0]  word_o
);

    localparam logic [19:0] MODE_IDLE  = 20'h25F98;
    localparam logic [19:0] MODE_CAL   = 20'h25F9A;
    localparam logic [19:0] MODE_RXTX  = 20'h25F94;
    localparam logic [19:0] MODE_RSSIO = 20'h27FD4;

    logic [3:0]  ch4;
    logic [3:0]  cfg4;
    logic [2:0]  pair;
    logic [15:0] synth_v;
    logic [15:0] vco_v;
    logic [19:0] gain_v;

    // Narrow the captured fields to the lookup widths.
    always_comb begin
        ch4  = 4'(chan_i);
        cfg4 = 4'(cfg_i);
        pair = 3'((ch4 - 4'd1) >> 1);
    end

    // Per-mode synth and oscillator selection.
    always_comb begin
        synth_v = auto_i ? auto_synth(ch4) : {8'h00, std_synth(ch4)};
        vco_v   = auto_i ? VCO_AUTOCAL : vco_std(cfg4, pair);
    end

    // Gain lookup and range check.
    always_comb begin
        gain_ok_o = (pwr_i < PWR_W'(GAIN_DEPTH));
        gain_v    = tx_gain(5'(pwr_i));
    end

    // Word assembly: address in the top nibble, value below.
    always_comb begin
        case (step_i)
            STEP_SYNTH: word_o = {4'd1, 4'h0, synth_v};
            STEP_DIV:   word_o = {4'd2, 8'h00, divide_ratio(ch4)};
            STEP_VCO:   word_o = {4'd3, VCO_FORCE_BITS | {4'h0, vco_v}};
            STEP_MODE0: word_o = {4'd0, MODE_IDLE};
            STEP_MODE1: word_o = {4'd0, MODE_CAL};
            STEP_MODE2: word_o = {4'd0, MODE_RXTX};
            STEP_MODE3: word_o = {4'd0, MODE_RSSIO};
            default:    word_o = {4'd7, gain_v};
        endcase
    end

endmodule

// File: rtl/chan_tune_seq.sv
// Module: chan_tune_seq (top)
// Radio channel tuning sequencer: on start, emits the ordered synth, divide,
// oscillator, mode and gain writes for the requested channel.
// Assumes the downstream shifter consumes one word per ready handshake.
module chan_tune_seq
    import chan_tune_pkg::*;
#(
    parameter int unsigned CHAN_W     = 4,
    parameter int unsigned CFG_W      = 4,
    parameter int unsigned PWR_W      = 8,
    parameter int unsigned CHAN_MAX   = 14,
    parameter int unsigned NUM_CFG    = 11,
    parameter int unsigned GAIN_DEPTH = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [CFG_W-1:0]  cfg_idx_i,
    input  logic              autocal_i,
    input  logic [PWR_W-1:0]  pwr_int_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [23:0]       wr_word_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    step_e             step;
    logic              gain_ok;
    logic [CHAN_W-1:0] chan_q;
    logic [CFG_W-1:0]  cfg_q;
    logic              auto_q;
    logic [PWR_W-1:0]  pwr_q;

    chan_tune_ctrl #(
        .CHAN_W(CHAN_W), .CFG_W(CFG_W), .PWR_W(PWR_W),
        .CHAN_MAX(CHAN_MAX), .NUM_CFG(NUM_CFG)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .chan_i(chan_i), .cfg_i(cfg_idx_i), .auto_i(autocal_i), .pwr_i(pwr_int_i),
        .ready_i(wr_ready_i), .gain_ok_i(gain_ok),
        .valid_o(wr_valid_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .step_o(step), .chan_q(chan_q), .cfg_q(cfg_q), .auto_q(auto_q), .pwr_q(pwr_q)
    );

    chan_tune_rom #(
        .CHAN_W(CHAN_W), .CFG_W(CFG_W), .PWR_W(PWR_W), .GAIN_DEPTH(GAIN_DEPTH)
    ) u_rom (
        .step_i(step), .chan_i(chan_q), .cfg_i(cfg_q), .auto_i(auto_q), .pwr_i(pwr_q),
        .gain_ok_o(gain_ok), .word_o(wr_word_o)
    );

    // A stalled word stays put until accepted.
    p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_word_o)));

    // No gain write is offered when the gain index is out of range.
    p_gain_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !gain_ok) |-> (wr_word_o[23:20] != 4'd7));

    // The oscillator word always carries the forced upper bits.
    p_vco_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_word_o[23:20] == 4'd3) |-> wr_word_o[18]);

    // Valid only while busy.
    p_valid_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> busy_o);

endmodule

// File: tb/tb_chan_tune_seq.sv
`timescale 1ns/100ps
module tb_chan_tune_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  chan_i = '0;
    logic [3:0]  cfg_idx_i = '0;
    logic        autocal_i = 1'b0;
    logic [7:0]  pwr_int_i = '0;
    logic        wr_ready_i = 1'b0;
    logic        wr_valid_o;
    logic [23:0] wr_word_o;
    logic        busy_o, done_o, err_o;

    int total = 0;
    int bad = 0;
    logic [23:0] exp_w [8];
    logic [23:0] got_w [8];
    int          got_n;
    logic        saw_done;

    always #2.5 clk = ~clk;

    chan_tune_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .cfg_idx_i(cfg_idx_i), .autocal_i(autocal_i), .pwr_int_i(pwr_int_i),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_word_o(wr_word_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic set_modes(input logic [19:0] gain);
        exp_w[3] = 24'h025F98; exp_w[4] = 24'h025F9A;
        exp_w[5] = 24'h025F94; exp_w[6] = 24'h027FD4;
        exp_w[7] = {4'd7, gain};
    endtask

    task automatic launch(input logic [3:0] ch, input logic [3:0] cfg, input logic au, input logic [7:0] pw);
        @(negedge clk);
        chan_i = ch; cfg_idx_i = cfg; autocal_i = au; pwr_int_i = pw; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Collect words until done; bp selects irregular ready. Checks R8 holding.
    task automatic collect(input bit bp);
        logic        stalled = 1'b0;
        logic [23:0] held = '0;
        got_n = 0; saw_done = 1'b0;
        for (int cyc = 0; cyc < 60; cyc++) begin
            if (done_o) begin saw_done = 1'b1; break; end
            if (stalled) chk(wr_valid_o && wr_word_o == held, "R8 hold", wr_word_o, held);
            wr_ready_i = bp ? (cyc % 3 != 1) : 1'b1;
            if (wr_valid_o && wr_ready_i && got_n < 8) begin
                got_w[got_n] = wr_word_o; got_n++;
            end
            stalled = wr_valid_o && !wr_ready_i;
            held = wr_word_o;
            @(negedge clk);
        end
        wr_ready_i = 1'b0;
    endtask

    task automatic compare(input int n, input string req);
        chk(saw_done, {req, " R9 done seen"}, saw_done, 1);
        chk(got_n == n, {req, " R1 word count"}, got_n, n);
        for (int i = 0; i < n && i < got_n; i++)
            chk(got_w[i] == exp_w[i], {req, " word"}, got_w[i], exp_w[i]);
        @(negedge clk);
        chk(!done_o && !busy_o, "R9 done single cycle", done_o, 0);
    endtask

    task automatic t_reset;
        chk(!wr_valid_o && !busy_o && !done_o && !err_o, "reset state", {wr_valid_o, busy_o, done_o, err_o}, 0);
    endtask

    task automatic t_ch1_std;  // R1 R2 R3 R4 R5 R6 R7 R12
        exp_w[0] = 24'h100047; exp_w[1] = 24'h200999; exp_w[2] = 24'h34664D;
        set_modes(20'h3FFFF);
        launch(4'd1, 4'd0, 1'b0, 8'h12);
        collect(1'b0);
        compare(8, "R1/R2/R3/R4/R6/R7 ch1 cfg0");
    endtask

    task automatic t_ch14_auto;  // R2 R3 R4 R5
        exp_w[0] = 24'h10684F; exp_w[1] = 24'h200CCC; exp_w[2] = 24'h346662;
        set_modes(20'h0E313);
        launch(4'd14, 4'd15, 1'b1, 8'h00);
        collect(1'b0);
        compare(8, "R2/R4/R5 ch14 autocal");
    endtask

    task automatic t_ch12_bp;  // R4 R8
        exp_w[0] = 24'h100077; exp_w[1] = 24'h20099A; exp_w[2] = 24'h34644B;
        set_modes(20'h361D7);
        launch(4'd12, 4'd10, 1'b0, 8'h0D);
        collect(1'b1);
        compare(8, "R4/R8 ch12 cfg10 backpressure");
    endtask

    task automatic t_ch7_cfg3;  // R3 R4
        exp_w[0] = 24'h100057; exp_w[1] = 24'h200998; exp_w[2] = 24'h34645D;
        set_modes(20'h0FB13);
        launch(4'd7, 4'd3, 1'b0, 8'h01);
        collect(1'b0);
        compare(8, "R3/R4 ch7 cfg3");
    endtask

    task automatic t_gain_skip;  // R7
        exp_w[0] = 24'h100067; exp_w[1] = 24'h20099B; exp_w[2] = 24'h34667D;
        set_modes(20'h0);
        launch(4'd6, 4'd4, 1'b0, 8'd19);
        collect(1'b0);
        compare(7, "R7 gain index 19 skipped");
    endtask

    task automatic t_busy_ignore;  // R10
        exp_w[0] = 24'h100047; exp_w[1] = 24'h20099B; exp_w[2] = 24'h34664D;
        set_modes(20'h3FFFF);
        launch(4'd2, 4'd0, 1'b0, 8'h12);
        wr_ready_i = 1'b0;
        chan_i = 4'd14; autocal_i = 1'b1; pwr_int_i = 8'h00; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R10 still busy", busy_o, 1);
        collect(1'b0);
        compare(8, "R10 start while busy ignored");
    endtask

    task automatic t_reject(input logic [3:0] ch, input logic [3:0] cfg, input string tag);  // R11
        launch(ch, cfg, 1'b0, 8'h00);
        chk(err_o && !wr_valid_o, {"R11 err pulse ", tag}, {err_o, wr_valid_o}, 2'b10);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!wr_valid_o && !done_o && !err_o && !busy_o, {"R11 no writes ", tag},
                {wr_valid_o, done_o, err_o, busy_o}, 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ch1_std();
        t_ch14_auto();
        t_ch12_bp();
        t_ch7_cfg3();
        t_gain_skip();
        t_busy_ignore();
        t_reject(4'd0, 4'd0, "ch0");
        t_reject(4'd15, 4'd0, "ch15");
        t_reject(4'd5, 4'd11, "cfg11");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule